// File: doc/BRIEF.md
# Consecutive-Event Overcurrent Fault Integrator

This block decides when repeated half-bridge over-current becomes a latched fault. It runs next to the half-bridge gate generator. It watches the low-side gate request and a synchronised over-current comparator flag. Each low-side period is one observation window. A flag seen while the low-side gate is high marks the window as faulty. A flag seen at any other time is ignored.

At the end of every window, an up/down counter takes one step. It steps up after a faulty window and down after a clean one, and it never goes below zero. Isolated over-current events therefore decay away. A sustained condition climbs to a programmable event count, and at that count the fault latch sets.

While the fault is latched, the block forces all three gate outputs low: high-side, low-side and PFC. It also holds the PFC compensation clear line high. The latch is released only by the supply-undervoltage input, which also returns the counter to zero.

Top module: `oc_event_integrator`

## Requirements
- R1: After reset, `count_o` is 0, `fault_o` is 0 and `comp_clr_o` is 0.
- R2: The over-current flag counts only in clock cycles where `lo_req_i` is 1. A flag raised only while `lo_req_i` is 0 (including the cycle LO is first seen low) leaves the window clean.
- R3: A window with one or more flagged cycles raises `count_o` by exactly one, no matter how many cycles were flagged.
- R4: A clean window lowers `count_o` by one. A clean window at zero leaves it at 0.
- R5: A window closes at the first clock edge that samples `lo_req_i` low after it was high. `count_o` still shows the old value after that edge and shows the new value after the next edge.
- R6: `fault_o` rises in the same cycle that `count_o` reaches `EVENT_LIMIT` (default 65). While the fault is latched, further windows leave `count_o` at `EVENT_LIMIT`.
- R7: While `fault_o` is 1, `ho_o`, `lo_o` and `pfc_o` are 0 and `comp_clr_o` is 1. Otherwise each gate output follows its request input in the same cycle.
- R8: The fault stays latched until `uvlo_i` is sampled high. One such cycle clears `fault_o`, clears `count_o` to 0 and discards any partly captured window. Nothing else clears the fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| uvlo_i | input | 1 | Supply undervoltage, synchronous clear of latch and counter |
| cs_over_i | input | 1 | Synchronised over-current comparator flag |
| ho_req_i | input | 1 | High-side gate request |
| lo_req_i | input | 1 | Low-side gate request, defines the windows |
| pfc_req_i | input | 1 | PFC gate request |
| ho_o | output | 1 | Gated high-side drive |
| lo_o | output | 1 | Gated low-side drive |
| pfc_o | output | 1 | Gated PFC drive |
| comp_clr_o | output | 1 | Forces PFC compensation state to zero |
| fault_o | output | 1 | Latched fault |
| count_o | output | CNT_W | Current event count |

## Verification
The count result is due two clock edges after the last high `lo_req_i` cycle. The first edge captures the window and the second updates the counter. The bench samples `count_o` at mid-cycle after each of these edges. It expects the old value after the first edge and the model's value after the second. The fault flag appears together with the terminal count, so it is sampled at the same point. Gate masking and the compensation clear are combinational from the latch, so they are checked one nanosecond after the request is driven. Clearing by undervoltage is checked one edge after `uvlo_i` is applied.

// File: rtl/ocf_pkg.sv
package ocf_pkg;
  typedef enum logic [1:0] {
    CNT_HOLD  = 2'd0,
    CNT_UP    = 2'd1,
    CNT_DOWN  = 2'd2,
    CNT_CLEAR = 2'd3
  } cnt_op_e;

  localparam int unsigned GATE_HO  = 0;
  localparam int unsigned GATE_LO  = 1;
  localparam int unsigned GATE_PFC = 2;
  localparam int unsigned N_GATES  = 3;
endpackage

// File: rtl/ocf_lo_sampler.sv
module ocf_lo_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic lo_i,
  input  logic cs_i,
  output logic evt_valid_o,
  output logic evt_hit_o
);
  logic lo_q;
  logic sticky_q;
  logic lo_fall;

  assign lo_fall = lo_q & ~lo_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q        <= 1'b0;
      sticky_q    <= 1'b0;
      evt_valid_o <= 1'b0;
      evt_hit_o   <= 1'b0;
    end else if (clr_i) begin
      lo_q        <= 1'b0;
      sticky_q    <= 1'b0;
      evt_valid_o <= 1'b0;
      evt_hit_o   <= 1'b0;
    end else begin
      lo_q        <= lo_i;
      evt_valid_o <= lo_fall;
      evt_hit_o   <= lo_fall & sticky_q;
      // flag collected only while LO is high; restart after each window
      if (lo_fall) sticky_q <= 1'b0;
      else         sticky_q <= sticky_q | (lo_i & cs_i);
    end
  end

  // R5
  evt_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |=> !evt_valid_o);

  // R2
  hit_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_hit_o |-> evt_valid_o);
endmodule

// File: rtl/ocf_updown_counter.sv
module ocf_updown_counter
  import ocf_pkg::*;
#(
  parameter int unsigned LIMIT = 65,
  parameter int unsigned CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             hold_i,
  input  logic             evt_valid_i,
  input  logic             evt_hit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             reach_o
);
  localparam logic [CNT_W-1:0] TOP     = CNT_W'(LIMIT);
  localparam logic [CNT_W-1:0] PRE_TOP = CNT_W'(LIMIT - 1);

  cnt_op_e op;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    op = CNT_HOLD;
    if (clr_i)                             op = CNT_CLEAR;
    else if (hold_i || !evt_valid_i)       op = CNT_HOLD;
    else if (evt_hit_i && cnt_q != TOP)    op = CNT_UP;
    else if (!evt_hit_i && cnt_q != '0)    op = CNT_DOWN;
  end

  assign reach_o = (op == CNT_UP) && (cnt_q == PRE_TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else begin
      unique case (op)
        CNT_CLEAR: cnt_q <= '0;
        CNT_UP:    cnt_q <= cnt_q + 1'b1;
        CNT_DOWN:  cnt_q <= cnt_q - 1'b1;
        default:   cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o = cnt_q;

  // R6
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TOP);

  // R5
  cnt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_valid_i && !clr_i) |=> $stable(cnt_q));

  // R4
  cnt_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && !evt_hit_i && cnt_q == '0 && !clr_i) |=> cnt_q == '0);

  // R8
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/ocf_fault_latch.sv
module ocf_fault_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic set_i,
  output logic fault_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    fault_o <= 1'b0;
    else if (clr_i) fault_o <= 1'b0;
    else if (set_i) fault_o <= 1'b1;
  end

  // R8
  fault_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !clr_i) |=> fault_o);
endmodule

// File: rtl/ocf_gate_mask.sv
module ocf_gate_mask
  import ocf_pkg::*;
(
  input  logic               kill_i,
  input  logic [N_GATES-1:0] req_i,
  output logic [N_GATES-1:0] drv_o
);
  for (genvar g = 0; g < N_GATES; g++) begin : g_chan
    assign drv_o[g] = req_i[g] & ~kill_i;
  end

  // R7
  always_comb begin
    gate_kill_chk: assert (!(kill_i && (drv_o != '0)));
  end
endmodule

// File: rtl/oc_event_integrator.sv
module oc_event_integrator
  import ocf_pkg::*;
#(
  parameter int unsigned EVENT_LIMIT = 65,
  parameter int unsigned CNT_W       = $clog2(EVENT_LIMIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             uvlo_i,
  input  logic             cs_over_i,
  input  logic             ho_req_i,
  input  logic             lo_req_i,
  input  logic             pfc_req_i,
  output logic             ho_o,
  output logic             lo_o,
  output logic             pfc_o,
  output logic             comp_clr_o,
  output logic             fault_o,
  output logic [CNT_W-1:0] count_o
);
  logic evt_valid, evt_hit, reach, fault_q;
  logic [N_GATES-1:0] req, drv;

  ocf_lo_sampler u_sampler (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (uvlo_i),
    .lo_i        (lo_req_i),
    .cs_i        (cs_over_i),
    .evt_valid_o (evt_valid),
    .evt_hit_o   (evt_hit)
  );

  ocf_updown_counter #(.LIMIT(EVENT_LIMIT), .CNT_W(CNT_W)) u_counter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (uvlo_i),
    .hold_i      (fault_q),
    .evt_valid_i (evt_valid),
    .evt_hit_i   (evt_hit),
    .cnt_o       (count_o),
    .reach_o     (reach)
  );

  ocf_fault_latch u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (uvlo_i),
    .set_i   (reach),
    .fault_o (fault_q)
  );

  assign req[GATE_HO]  = ho_req_i;
  assign req[GATE_LO]  = lo_req_i;
  assign req[GATE_PFC] = pfc_req_i;

  ocf_gate_mask u_mask (
    .kill_i (fault_q),
    .req_i  (req),
    .drv_o  (drv)
  );

  assign ho_o       = drv[GATE_HO];
  assign lo_o       = drv[GATE_LO];
  assign pfc_o      = drv[GATE_PFC];
  assign comp_clr_o = fault_q;
  assign fault_o    = fault_q;

  // R6
  fault_at_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_q) |-> count_o == CNT_W'(EVENT_LIMIT));

  // R6
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_q && !uvlo_i) |=> count_o == CNT_W'(EVENT_LIMIT));
endmodule

// File: tb/oc_event_integrator_tb.sv
`timescale 1ns/1ps
module oc_event_integrator_tb;
  localparam int LIMIT = 65;
  localparam int CW = $clog2(LIMIT + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic uvlo = 0, cs = 0, ho_req = 0, lo_req = 0, pfc_req = 0;
  logic ho, lo, pfc, cclr, fault;
  logic [CW-1:0] cnt;

  int n_run = 0, n_fail = 0;
  int exp_cnt = 0;
  bit exp_fault = 0;
  bit done = 0;

  always #4 clk = ~clk;

  oc_event_integrator #(.EVENT_LIMIT(LIMIT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .uvlo_i(uvlo), .cs_over_i(cs),
    .ho_req_i(ho_req), .lo_req_i(lo_req), .pfc_req_i(pfc_req),
    .ho_o(ho), .lo_o(lo), .pfc_o(pfc), .comp_clr_o(cclr),
    .fault_o(fault), .count_o(cnt)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int model_cnt(input int c, input bit f, input bit hit);
    if (f) return c;
    if (hit) return (c < LIMIT) ? c + 1 : c;
    return (c > 0) ? c - 1 : 0;
  endfunction

  // one LO window: hi_len high cycles, flag on cycle pos (if hit), junk flag while low
  task automatic lo_window(input int hi_len, input bit hit, input bit junk);
    int pos = int'($urandom_range(hi_len - 1, 0));
    int prev = exp_cnt;
    for (int i = 0; i < hi_len; i++) begin
      @(negedge clk);
      lo_req  = 1'b1;
      ho_req  = 1'b0;
      pfc_req = 1'($urandom_range(1, 0));
      cs      = hit && ((i == pos) || ($urandom_range(3, 0) == 0));
      if (i == 0) begin
        #1;
        // R7
        check("R7 lo_o", lo, exp_fault ? 0 : 1);
        check("R7 pfc_o", pfc, exp_fault ? 0 : pfc_req);
        check("R7 comp_clr_o", cclr, exp_fault);
      end
    end
    @(negedge clk);
    lo_req = 1'b0;
    ho_req = 1'b1;
    cs     = junk;
    @(negedge clk);
    cs     = junk;
    // R5: window closed at one edge, count not yet moved
    check("R5 count after first edge", cnt, prev);
    exp_cnt = model_cnt(exp_cnt, exp_fault, hit);
    if (exp_cnt == LIMIT) exp_fault = 1;
    @(negedge clk);
    cs = 1'b0;
    check("R3/R4 count", cnt, exp_cnt);
    check("R6 fault", fault, exp_fault);
    #1;
    check("R7 ho_o", ho, exp_fault ? 0 : 1);
  endtask

  task automatic do_uvlo();
    @(negedge clk);
    uvlo = 1'b1;
    lo_req = 1'b1;
    cs = 1'b1;
    @(negedge clk);
    uvlo = 1'b0;
    lo_req = 1'b0;
    cs = 1'b0;
    exp_cnt = 0;
    exp_fault = 0;
    // R8
    check("R8 count cleared", cnt, 0);
    check("R8 fault cleared", fault, 0);
    @(negedge clk);
    @(negedge clk);
    // R8: partial window captured before uvlo discarded
    check("R8 no stale window", cnt, 0);
  endtask

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    // R1
    check("R1 count", cnt, 0);
    check("R1 fault", fault, 0);
    check("R1 comp_clr", cclr, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 floor at zero, R2 flag while low ignored
    lo_window(2, 0, 1);
    lo_window(3, 0, 1);
    // R3 several flags in one window count once
    lo_window(4, 1, 0);
    lo_window(4, 1, 1);
    check("R3 two windows", cnt, 2);
    // R2 junk-only window is clean
    lo_window(3, 0, 1);
    check("R2 junk ignored", cnt, 1);
    // alternating windows never build up
    for (int k = 0; k < 20; k++) lo_window(1, k[0], 0);
    check("R4 alternating bounded", (cnt <= 2) ? 1 : 0, 1);

    // random mix
    for (int k = 0; k < 150; k++) begin
      int bias = (k < 75) ? 3 : 1;
      lo_window(int'($urandom_range(4, 1)), ($urandom_range(3, 0) < bias), 1'($urandom_range(1, 0)));
    end

    do_uvlo();
    // R6 sustained over-current reaches the limit
    for (int k = 0; k < LIMIT; k++) lo_window(2, 1, 0);
    check("R6 fault at limit", fault, 1);
    check("R6 count at limit", cnt, LIMIT);
    // R6 saturation, R8 fault not cleared by clean windows
    for (int k = 0; k < 5; k++) lo_window(2, k[0], 0);
    check("R8 fault held", fault, 1);
    check("R6 count held", cnt, LIMIT);
    do_uvlo();
    lo_window(2, 1, 0);
    check("R8 restart counts", cnt, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule